// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives the transmit side of a network controller from a ring of descriptors kept in a shared 16-bit memory. The host prepares a buffer, writes a descriptor for it and hands the descriptor over by setting its ownership bit. The engine finds such descriptors, reads the buffer address and the byte count, and sends the buffer's bytes one at a time on a ready/valid byte stream towards the MAC. When a frame ends it collects the MAC's completion report, writes the result into the descriptor, clears ownership and pulses an interrupt.

Each descriptor takes four consecutive memory words at `ring_base_i + 4*index`. Word 0 holds the low 16 bits of the buffer's byte address. Word 1 holds the flag byte in bits 15:8 and the upper address byte in bits 7:0. Word 2 holds the byte count as a negative two's complement number. Word 3 holds the detailed status. Bytes are packed big-endian: the even byte address is the upper half of a word. A frame can span several descriptors. A descriptor whose end flag is clear passes on to the next one, and the engine checks ownership of that next descriptor before it releases the current one.

Scanning begins after a start command and is triggered again either by a demand pulse or by an internal poll timer. A frame whose chain runs into a descriptor the host still holds is cut short as a buffer underflow. That also switches the transmitter off until the next start.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the transmitter is off (`tx_on_o` low), and `tx_valid_o`, `mem_req_o` and `tx_irq_o` are low.
- R2: A `start_i` pulse while off turns the transmitter on and reads the flag word (offset 1) of the current descriptor in the next cycle. A descriptor without the ownership bit (flag bit 7) leaves the engine waiting at the same index, and no bytes are sent.
- R3: A `demand_i` pulse while the engine waits causes a read of the current flag word in the next cycle.
- R4: With no demand, the current flag word is read again every POLL_CYCLES+2 cycles, counted from one flag read to the next.
- R5: An owned descriptor with byte count word N (two's complement) sends exactly -N bytes, starting at byte address {word1[7:0], word0}, in ascending address order, with the even address taken from bits 15:8. Data stays stable while `tx_ready_i` is low.
- R6: `tx_last_o` is high only on the final byte of a descriptor whose end flag (bit 0) is set.
- R7: After the final byte of an end descriptor, the engine waits for `mac_done_i`. It then writes status word 3 as {buffer error 15, underflow 14, late collision 12, lost carrier 11, retry failure 10, TDR 9:0}. Next it writes flag word 1 with ownership cleared, error summary (bit 6) = retry failure | lost carrier | late collision, more retries bit 4, one retry bit 3, deferred bit 2, start and end flags kept (bits 1, 0) and the upper address byte kept. Finally it pulses `tx_irq_o` for one cycle.
- R8: For a descriptor whose end flag is clear, if the next descriptor is owned, the engine writes flag word 1 with only the start and end bits kept and no interrupt. Bytes continue from the next descriptor's buffer.
- R9: If the next descriptor in a chain is not owned, the current descriptor gets status word 0xC000 (buffer error and underflow) and a flag with error summary set and ownership cleared. The interrupt pulses and the transmitter turns off. While off, demand and polling cause no memory access and no bytes. A later start resumes at the descriptor after the aborted one.
- R10: The ring holds 2^`ring_log2_i` descriptors, and the index wraps from the last entry back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| demand_i | input | 1 | Transmit-demand pulse |
| ring_base_i | input | AW | Word address of descriptor 0 |
| ring_log2_i | input | 3 | log2 of the ring size |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Byte data |
| tx_last_o | output | 1 | Last byte of a frame |
| tx_ready_i | input | 1 | Sink accepts byte |
| mac_done_i | input | 1 | MAC completion report strobe |
| mac_one_retry_i | input | 1 | Exactly one retry |
| mac_multi_retry_i | input | 1 | More than one retry |
| mac_deferred_i | input | 1 | Transmission deferred |
| mac_lost_carrier_i | input | 1 | Carrier lost |
| mac_late_col_i | input | 1 | Late collision |
| mac_retry_fail_i | input | 1 | Retry limit exhausted |
| mac_tdr_i | input | 10 | Time-domain reflectometry count |
| tx_irq_o | output | 1 | Transmit-done interrupt pulse |
| tx_on_o | output | 1 | Transmitter enabled |

## Verification
A wrong ring index shows at the ports in two ways: the next frame streams bytes from the wrong buffer, and its write-back lands at the wrong descriptor address. Both are visible within one descriptor fetch. A wrong byte pointer or count shows up on the very next byte or as a missing or extra last marker. A bad write-back shows as flag or status words that differ from the expected encoding when the interrupt fires. The enable state is observed directly: after an underflow, any memory request or byte before the next start exposes it within a poll period.

// File: rtl/tx_ring_pkg.sv
`timescale 1ns/1ps
package tx_ring_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_WAIT, S_RFLAG, S_CFLAG, S_RLO, S_CLO, S_RLEN, S_CLEN,
    S_FETCH, S_FWAIT, S_EMIT, S_LOOK, S_CLOOK, S_MAC, S_WMISC, S_WFLAG
  } eng_state_e;

  typedef enum logic [1:0] {WB_CHAIN, WB_END, WB_UFLO} wb_kind_e;

  typedef struct packed {
    logic       one;
    logic       more;
    logic       def;
    logic       lcar;
    logic       lcol;
    logic       rtry;
    logic [9:0] tdr;
  } mac_stat_t;

  localparam int FB_OWN  = 7;
  localparam int FB_ERR  = 6;
  localparam int FB_MORE = 4;
  localparam int FB_ONE  = 3;
  localparam int FB_DEF  = 2;
  localparam int FB_STP  = 1;
  localparam int FB_ENP  = 0;

  localparam int MB_BUFF = 15;
  localparam int MB_UFLO = 14;
  localparam int MB_LCOL = 12;
  localparam int MB_LCAR = 11;
  localparam int MB_RTRY = 10;

  localparam int OFF_LO   = 0;
  localparam int OFF_FLAG = 1;
  localparam int OFF_LEN  = 2;
  localparam int OFF_MISC = 3;

endpackage

// File: rtl/tx_poll_timer.sv
`timescale 1ns/1ps
module tx_poll_timer #(
  parameter int POLL_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(POLL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/tx_ring_ptr.sv
`timescale 1ns/1ps
module tx_ring_ptr #(
  parameter int MAX_LOG2 = 7,
  localparam int IW = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    log2_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] nidx_o
);
  logic [IW-1:0] idx_q;
  logic [IW-1:0] mask;
  int            eff;

  always_comb begin
    eff  = (int'(log2_i) > MAX_LOG2) ? MAX_LOG2 : int'(log2_i);
    mask = '0;
    for (int b = 0; b < IW; b++) begin
      if (b < eff) mask[b] = 1'b1;
    end
  end

  assign nidx_o = (idx_q + 1'b1) & mask;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= nidx_o;
  end
endmodule

// File: rtl/tx_wb_pack.sv
`timescale 1ns/1ps
module tx_wb_pack
  import tx_ring_pkg::*;
(
  input  wb_kind_e    kind_i,
  input  logic [7:0]  flag_i,
  input  mac_stat_t   stat_i,
  output logic [7:0]  flag_o,
  output logic [15:0] misc_o
);
  always_comb begin
    flag_o         = '0;
    misc_o         = '0;
    flag_o[FB_STP] = flag_i[FB_STP];
    flag_o[FB_ENP] = flag_i[FB_ENP];
    unique case (kind_i)
      WB_END: begin
        flag_o[FB_MORE] = stat_i.more;
        flag_o[FB_ONE]  = stat_i.one;
        flag_o[FB_DEF]  = stat_i.def;
        flag_o[FB_ERR]  = stat_i.lcar | stat_i.lcol | stat_i.rtry;
        misc_o[9:0]     = stat_i.tdr;
        misc_o[MB_LCOL] = stat_i.lcol;
        misc_o[MB_LCAR] = stat_i.lcar;
        misc_o[MB_RTRY] = stat_i.rtry;
      end
      WB_UFLO: begin
        flag_o[FB_ERR]  = 1'b1;
        misc_o[MB_BUFF] = 1'b1;
        misc_o[MB_UFLO] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_ring_engine.sv
`timescale 1ns/1ps
module tx_ring_engine
  import tx_ring_pkg::*;
#(
  parameter int AW          = 16,
  parameter int POLL_CYCLES = 64,
  parameter int MAX_LOG2    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          demand_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [2:0]    ring_log2_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  input  logic          mac_done_i,
  input  logic          mac_one_retry_i,
  input  logic          mac_multi_retry_i,
  input  logic          mac_deferred_i,
  input  logic          mac_lost_carrier_i,
  input  logic          mac_late_col_i,
  input  logic          mac_retry_fail_i,
  input  logic [9:0]    mac_tdr_i,
  output logic          tx_irq_o,
  output logic          tx_on_o
);
  localparam int IW = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
  localparam int PW = AW + 1;

  eng_state_e    state;
  wb_kind_e      kind_q;
  mac_stat_t     stat_q;
  logic [7:0]    cur_flag, cur_hi, look_flag, look_hi;
  logic [15:0]   cur_lo, cnt_q, word_q;
  logic [PW-1:0] ptr_q;
  logic          irq_q;

  logic [IW-1:0] idx, nidx;
  logic [AW-1:0] cur_base, nxt_base;
  logic [7:0]    pk_flag;
  logic [15:0]   pk_misc;
  logic [15:0]   neg_len;
  logic          expire, adv;
  eng_state_e    post_state;

  tx_ring_ptr #(.MAX_LOG2(MAX_LOG2)) u_ptr (
    .clk_i, .rst_ni, .log2_i(ring_log2_i), .adv_i(adv), .idx_o(idx), .nidx_o(nidx)
  );

  tx_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk_i, .rst_ni, .run_i(state == S_WAIT), .expire_o(expire)
  );

  tx_wb_pack u_pack (
    .kind_i(kind_q), .flag_i(cur_flag), .stat_i(stat_q), .flag_o(pk_flag), .misc_o(pk_misc)
  );

  assign cur_base   = ring_base_i + AW'({idx, 2'b00});
  assign nxt_base   = ring_base_i + AW'({nidx, 2'b00});
  assign neg_len    = ~mem_rdata_i + 16'd1;
  assign adv        = (state == S_WFLAG);
  assign post_state = cur_flag[FB_ENP] ? S_MAC : S_LOOK;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_base;
    mem_wdata_o = '0;
    unique case (state)
      S_RFLAG: begin mem_req_o = 1'b1; mem_addr_o = cur_base + AW'(OFF_FLAG); end
      S_RLO:   begin mem_req_o = 1'b1; mem_addr_o = cur_base + AW'(OFF_LO);   end
      S_RLEN:  begin mem_req_o = 1'b1; mem_addr_o = cur_base + AW'(OFF_LEN);  end
      S_FETCH: begin mem_req_o = 1'b1; mem_addr_o = ptr_q[PW-1:1];            end
      S_LOOK:  begin mem_req_o = 1'b1; mem_addr_o = nxt_base + AW'(OFF_FLAG); end
      S_WMISC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_base + AW'(OFF_MISC);
        mem_wdata_o = pk_misc;
      end
      S_WFLAG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_base + AW'(OFF_FLAG);
        mem_wdata_o = {pk_flag, cur_hi};
      end
      default: ;
    endcase
  end

  assign tx_valid_o = (state == S_EMIT);
  assign tx_data_o  = ptr_q[0] ? word_q[7:0] : word_q[15:8];
  assign tx_last_o  = tx_valid_o && (cnt_q == 16'd1) && cur_flag[FB_ENP];
  assign tx_irq_o   = irq_q;
  assign tx_on_o    = (state != S_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_OFF;
      kind_q    <= WB_CHAIN;
      stat_q    <= '0;
      cur_flag  <= '0;
      cur_hi    <= '0;
      cur_lo    <= '0;
      look_flag <= '0;
      look_hi   <= '0;
      cnt_q     <= '0;
      word_q    <= '0;
      ptr_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state)
        S_OFF:   if (start_i) state <= S_RFLAG;
        S_WAIT:  if (demand_i || expire) state <= S_RFLAG;
        S_RFLAG: state <= S_CFLAG;
        S_CFLAG: begin
          cur_flag <= mem_rdata_i[15:8];
          cur_hi   <= mem_rdata_i[7:0];
          state    <= mem_rdata_i[8+FB_OWN] ? S_RLO : S_WAIT;
        end
        S_RLO:   state <= S_CLO;
        S_CLO: begin
          cur_lo <= mem_rdata_i;
          state  <= S_RLEN;
        end
        S_RLEN:  state <= S_CLEN;
        S_CLEN: begin
          cnt_q <= neg_len;
          ptr_q <= PW'({cur_hi, cur_lo});
          state <= (neg_len == 16'd0) ? post_state : S_FETCH;
        end
        S_FETCH: state <= S_FWAIT;
        S_FWAIT: begin
          word_q <= mem_rdata_i;
          state  <= S_EMIT;
        end
        S_EMIT: if (tx_ready_i) begin
          ptr_q <= ptr_q + 1'b1;
          cnt_q <= cnt_q - 16'd1;
          if (cnt_q == 16'd1) state <= post_state;
          else if (ptr_q[0])  state <= S_FETCH;
        end
        S_LOOK:  state <= S_CLOOK;
        S_CLOOK: begin
          look_flag <= mem_rdata_i[15:8];
          look_hi   <= mem_rdata_i[7:0];
          if (mem_rdata_i[8+FB_OWN]) begin
            kind_q <= WB_CHAIN;
            state  <= S_WFLAG;
          end else begin
            kind_q <= WB_UFLO;
            state  <= S_WMISC;
          end
        end
        S_MAC: if (mac_done_i) begin
          stat_q.one  <= mac_one_retry_i;
          stat_q.more <= mac_multi_retry_i;
          stat_q.def  <= mac_deferred_i;
          stat_q.lcar <= mac_lost_carrier_i;
          stat_q.lcol <= mac_late_col_i;
          stat_q.rtry <= mac_retry_fail_i;
          stat_q.tdr  <= mac_tdr_i;
          kind_q      <= WB_END;
          state       <= S_WMISC;
        end
        S_WMISC: state <= S_WFLAG;
        S_WFLAG: begin
          unique case (kind_q)
            WB_CHAIN: begin
              cur_flag <= look_flag;
              cur_hi   <= look_hi;
              state    <= S_RLO;
            end
            WB_END: begin
              irq_q <= 1'b1;
              state <= S_RFLAG;
            end
            default: begin
              irq_q <= 1'b1;
              state <= S_OFF;
            end
          endcase
        end
        default: state <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_engine_chk.sv
`timescale 1ns/1ps
module tx_ring_engine_chk
  import tx_ring_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          demand_i,
  input logic [AW-1:0] ring_base_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [15:0]   mem_wdata_o,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic          tx_ready_i,
  input logic          tx_irq_o,
  input logic          tx_on_o,
  input eng_state_e    state_i
);
  logic [AW-1:0] rel_addr;
  assign rel_addr = mem_addr_o - ring_base_i;

  assert_hold_stream_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && rel_addr[1:0] == 2'd1 |-> !mem_wdata_o[15]);

  assert_demand_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_WAIT && demand_i |=> mem_req_o && !mem_we_o && rel_addr[1:0] == 2'd1);

  assert_off_on_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_on_o) |-> tx_irq_o);

  assert_quiet_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_on_o |-> !mem_req_o && !tx_valid_o);
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .demand_i, .ring_base_i, .mem_req_o, .mem_we_o, .mem_addr_o,
  .mem_wdata_o, .tx_valid_o, .tx_data_o, .tx_last_o, .tx_ready_i, .tx_irq_o,
  .tx_on_o, .state_i(state)
);

// File: tb/sim_tx_ring_engine.sv
`timescale 1ns/1ps
module sim_tx_ring_engine;
  localparam int AW   = 12;
  localparam int POLL = 40;
  localparam logic [AW-1:0] BASE = 12'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, demand = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_irq, tx_on;
  logic [7:0] tx_data;
  logic ready = 1'b1;
  logic ready_mode = 1'b0;
  logic mac_done = 1'b0;
  logic m_one = 0, m_more = 0, m_def = 0, m_lcar = 0, m_lcol = 0, m_rtry = 0;
  logic [9:0] m_tdr = '0;

  logic [15:0] mem [0:4095];
  logic [7:0]  exp_q[$];
  bit          exp_l[$];
  int tests = 0, fails = 0, irq_cnt = 0, cyc = 0, mac_cd = 0;
  bit expect_quiet = 0;

  always #4 clk = ~clk;

  tx_ring_engine #(.AW(AW), .POLL_CYCLES(POLL), .MAX_LOG2(7)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .demand_i(demand),
    .ring_base_i(BASE), .ring_log2_i(3'd2),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_ready_i(ready),
    .mac_done_i(mac_done), .mac_one_retry_i(m_one), .mac_multi_retry_i(m_more),
    .mac_deferred_i(m_def), .mac_lost_carrier_i(m_lcar), .mac_late_col_i(m_lcol),
    .mac_retry_fail_i(m_rtry), .mac_tdr_i(m_tdr),
    .tx_irq_o(tx_irq), .tx_on_o(tx_on)
  );

  function automatic logic [7:0] pat(int b);
    return 8'((b * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
    ready <= ready_mode ? ~ready : 1'b1;
    if (mac_cd != 0) begin
      mac_cd   <= mac_cd - 1;
      mac_done <= (mac_cd == 1);
    end else mac_done <= 1'b0;
    if (tx_valid && ready && tx_last) mac_cd <= 3;
  end

  // reference stream: each accepted byte must match the model queue
  always @(negedge clk) begin
    if (tx_irq) irq_cnt++;
    if (tx_valid && ready) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected byte act=%0h exp=none", tx_data);
      end else begin
        logic [7:0] eb;
        bit el;
        eb = exp_q.pop_front();
        el = exp_l.pop_front();
        if (tx_data !== eb || tx_last !== el) begin
          fails++;
          $display("FAIL R5/R6 byte act=%0h/%0b exp=%0h/%0b", tx_data, tx_last, eb, el);
        end
      end
    end
    if (expect_quiet) begin
      tests++;
      if (mem_req || tx_valid) begin
        fails++;
        $display("FAIL R9 activity while off act=%0b%0b exp=00", mem_req, tx_valid);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int idx, input logic [23:0] ba, input int len, input logic [7:0] fl);
    int b;
    b = int'(BASE) + idx * 4;
    mem[b]     = ba[15:0];
    mem[b + 1] = {fl, ba[23:16]};
    mem[b + 2] = 16'(-len);
    mem[b + 3] = 16'h0;
  endtask

  task automatic expect_frame(input int ba, input int n, input bit last);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat(ba + i));
      exp_l.push_back(last && (i == n - 1));
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic wait_read(input logic [AW-1:0] a, output int c);
    do @(negedge clk); while (!(mem_req && !mem_we && mem_addr == a));
    c = cyc;
  endtask

  task automatic wait_irq(input int n);
    while (irq_cnt < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    int c0, c1;
    for (int w = 0; w < 4096; w++) mem[w] = {pat(2 * w), pat(2 * w + 1)};
    for (int d = 0; d < 4; d++) put_desc(d, 24'h0, 1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R1 tx_on", tx_on, 0);
    chk("R1 valid", tx_valid, 0);
    chk("R1 req", mem_req, 0);
    chk("R1 irq", tx_irq, 0);
    rst_n = 1'b1;

    // R2: start polls at once, unowned entry idles
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 first poll", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 12'h101});
    repeat (20) @(negedge clk);
    chk("R2 on", tx_on, 1);

    // R3: demand forces immediate read; single frame, odd start address, R7
    wait_read(12'h101, c0);
    repeat (3) @(negedge clk);
    put_desc(0, 24'h000801, 5, 8'h83);
    expect_frame(24'h801, 5, 1);
    m_one = 1; m_tdr = 10'h12;
    demand = 1'b1;
    @(negedge clk);
    demand = 1'b0;
    chk("R3 demand read", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 12'h101});
    wait_irq(1);
    chk("R7 misc0", mem[12'h103], 16'h0012);
    chk("R7 flag0", mem[12'h101], 16'h0B00);
    chk("R5 drained0", exp_q.size(), 0);

    // R4: periodic poll spacing, error status, stalled sink
    m_one = 0; m_more = 1; m_lcar = 1; m_tdr = 10'h3;
    ready_mode = 1'b1;
    wait_read(12'h105, c0);
    @(negedge clk);
    put_desc(1, 24'h000900, 6, 8'h83);
    expect_frame(24'h900, 6, 1);
    wait_read(12'h105, c1);
    chk("R4 poll gap", c1 - c0, POLL + 2);
    wait_irq(2);
    chk("R7 misc1", mem[12'h107], 16'h0803);
    chk("R7 flag1 err", mem[12'h105], 16'h5300);

    // R8: chained descriptors
    m_more = 0; m_lcar = 0; m_tdr = '0;
    ready_mode = 1'b0;
    repeat (2) @(negedge clk);
    put_desc(3, 24'h000B00, 4, 8'h81);
    put_desc(2, 24'h000A00, 3, 8'h82);
    expect_frame(24'hA00, 3, 0);
    expect_frame(24'hB00, 4, 1);
    pulse(demand);
    wait_irq(3);
    repeat (10) @(negedge clk);
    chk("R8 single irq", irq_cnt, 3);
    chk("R8 chain flag", mem[12'h109], 16'h0200);
    chk("R8 end flag", mem[12'h10D], 16'h0100);
    chk("R5 drained chain", exp_q.size(), 0);

    // R10: index wraps 3 -> 0
    put_desc(0, 24'h000C00, 2, 8'h83);
    expect_frame(24'hC00, 2, 1);
    pulse(demand);
    wait_irq(4);
    chk("R10 wrap flag", mem[12'h101], 16'h0300);
    chk("R10 wrap drained", exp_q.size(), 0);

    // R9: chain into unowned entry
    put_desc(2, 24'h000D00, 1, 8'h00);
    put_desc(1, 24'h000E00, 3, 8'h82);
    expect_frame(24'hE00, 3, 0);
    pulse(demand);
    wait_irq(5);
    repeat (2) @(negedge clk);
    chk("R9 off", tx_on, 0);
    chk("R9 misc", mem[12'h107], 16'hC000);
    chk("R9 flag", mem[12'h105], 16'h4200);
    put_desc(2, 24'h000D00, 1, 8'h83);
    expect_quiet = 1;
    pulse(demand);
    repeat (60) @(negedge clk);
    expect_quiet = 0;
    chk("R9 stays off", tx_on, 0);
    chk("R9 no irq", irq_cnt, 5);
    expect_frame(24'hD00, 1, 1);
    pulse(start);
    wait_irq(6);
    chk("R9 resume flag", mem[12'h109], 16'h0300);
    chk("R9 resume drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule